// File: doc/BRIEF.md
# Code Memory Byte-Programming Controller

This block is the programming-mode side of a small on-chip code store of 2048 bytes. While the programming enable is high, an external programmer reaches locations one after another with a step pulse instead of an address bus. The programmer picks a command with a two-bit mode field and launches a write or a whole-array erase with a program pulse. A ready flag reports when the timed cycle has finished.

The array is a behavioural register array. A written byte can only lose bits, so putting new contents in a used location means erasing the whole array first. While a write cycle runs, the programmer can read the byte just written to poll for completion: the top bit comes back inverted until the cycle ends. All inputs are sampled on the clock, and each pulse takes effect on its rising edge as seen at a clock edge.

Top module: `codemem_prog_ctrl`

## Requirements
- R1: After reset every location reads 0xFF, the address counter is 0x000 and `ready` is high.
- R2: A rising edge on `prog_en` clears the address counter to 0x000 at the next clock edge.
- R3: While `prog_en` is high, each rising edge on `step` adds one to the address counter at the next clock edge.
- R4: The address counter wraps from 0x7FF to 0x000.
- R5: A rising edge on `prog_pulse` with `mode_sel` = 2'b01 (write) and `ready` high stores `din` at the counter address of a blank byte.
- R6: A write to a byte that is not blank stores the bitwise AND of the old and new data.
- R7: A rising edge on `prog_pulse` with `mode_sel` = 2'b11 (erase) and `ready` high sets every byte to 0xFF.
- R8: After a write or erase starts, `ready` is low for exactly `WR_CYCLES` clock cycles and then returns high.
- R9: Rising edges on `prog_pulse` while `ready` is low have no effect on memory contents or on the cycle length.
- R10: In read mode during a write cycle, a read of the byte just written returns its bit 7 inverted and bits 6:0 true. After the cycle ends, all bits read true.
- R11: `dout` shows the byte at the counter address only when `prog_en` is high and `mode_sel` = 2'b10 (read). Otherwise it is 0x00, and 2'b00 means idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prog_en | input | 1 | Programming enable; a rising edge clears the address counter |
| step | input | 1 | Address step pulse |
| mode_sel | input | 2 | Command: 00 idle, 01 write, 10 read, 11 erase |
| prog_pulse | input | 1 | Program pulse that starts a write or erase |
| din | input | 8 | Byte to program |
| dout | output | 8 | Read data, 0x00 outside read mode |
| ready | output | 1 | High when no write or erase cycle is running |

## Verification
The bench keeps the default 11-bit address, so the full 2048-byte range and the wrap from 0x7FF to 0x000 can be reached with about four thousand clock cycles of stepping. It sets `WR_CYCLES` to 6. That keeps each write short enough for dozens of random writes, and still leaves room inside one busy window to poll, to inject an ignored program pulse, and to poll again.

// File: rtl/codemem_pkg.sv
// Package: shared command encoding for the code memory programming controller.
// Assumes a two-bit mode field from the programmer.
package codemem_pkg;
    typedef enum logic [1:0] {
        CM_IDLE  = 2'b00,
        CM_WRITE = 2'b01,
        CM_READ  = 2'b10,
        CM_ERASE = 2'b11
    } cm_mode_e;
endpackage

// File: rtl/cm_cmd_dec.sv
// Module: cm_cmd_dec
// Registers the pulse inputs to find their rising edges and decodes the
// mode field. Assumes all inputs are synchronous to clk. With prog_en
// low the command is forced to idle and the step and program edges are masked.
module cm_cmd_dec
    import codemem_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     prog_en,
    input  logic     step,
    input  logic     prog_pulse,
    input  logic [1:0] mode_sel,
    output cm_mode_e mode,
    output logic     en_rise,
    output logic     step_rise,
    output logic     prog_rise
);
    logic en_q, step_q, prog_q;

    // Hold the previous sample of each pulse input for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            step_q <= 1'b0;
            prog_q <= 1'b0;
        end else begin
            en_q   <= prog_en;
            step_q <= step;
            prog_q <= prog_pulse;
        end
    end

    // Decode the command and qualify the edges by the enable.
    always_comb begin
        mode      = prog_en ? cm_mode_e'(mode_sel) : CM_IDLE;
        en_rise   = prog_en & ~en_q;
        step_rise = prog_en & step & ~step_q;
        prog_rise = prog_en & prog_pulse & ~prog_q;
    end
endmodule

// File: rtl/cm_addr_ctr.sv
// Module: cm_addr_ctr
// Address counter that is cleared on request and advanced one location per
// step. Assumes clear and step arrive as single-cycle strobes, with clear
// taking priority. The counter wraps at the top of the address range.
module cm_addr_ctr #(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              adv,
    output logic [ADDR_W-1:0] addr
);
    // Clear, advance or hold the current location.
    always_ff @(posedge clk) begin
        if (!rst_n)   addr <= '0;
        else if (clr) addr <= '0;
        else if (adv) addr <= addr + 1'b1;
    end

    assert_addr_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (addr == '0));
    assert_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr) |=> (addr == $past(addr) + 1'b1));
    assert_addr_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !clr && (addr == {ADDR_W{1'b1}})) |=> (addr == '0));
endmodule

// File: rtl/cm_wr_timer.sv
// Module: cm_wr_timer
// Times one write or erase cycle of WR_CYCLES clocks and drives the ready
// flag. Assumes WR_CYCLES >= 1. A start strobe while a cycle runs is dropped.
module cm_wr_timer #(
    parameter int WR_CYCLES = 8,
    localparam int CNT_W = $clog2(WR_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic ready
);
    logic [CNT_W-1:0] cnt;

    // Load the cycle length on an accepted start, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cnt <= '0;
        else if (cnt != '0)           cnt <= cnt - 1'b1;
        else if (start)               cnt <= CNT_W'(WR_CYCLES);
    end

    // Flag the cycle while the counter is non-zero.
    always_comb begin
        busy  = (cnt != '0);
        ready = ~busy;
    end

    assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && ready) |=> !ready);
    assert_busy_ignores_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/cm_array.sv
// Module: cm_array
// Behavioural byte array with write-by-AND, whole-array erase and a read
// port with data polling. Assumes wr_go and erase_go are never high together
// and that each comes only when no cycle is running. Reset puts the array in
// the erased state.
module cm_array #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_go,
    input  logic              erase_go,
    input  logic              rd_en,
    input  logic              busy,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [ADDR_W-1:0] last_addr;
    logic [DATA_W-1:0] last_data;
    logic              poll_armed;

    // Update the cells: erase all, or clear bits in one byte.
    always_ff @(posedge clk) begin
        if (!rst_n || erase_go) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else if (wr_go) begin
            mem[addr] <= mem[addr] & din;
        end
    end

    // Remember the last written byte so it can be polled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_addr  <= '0;
            last_data  <= '1;
            poll_armed <= 1'b0;
        end else if (wr_go) begin
            last_addr  <= addr;
            last_data  <= mem[addr] & din;
            poll_armed <= 1'b1;
        end else if (erase_go) begin
            poll_armed <= 1'b0;
        end
    end

    // Drive read data, with bit 7 inverted while the written byte is in flight.
    always_comb begin
        if (!rd_en)
            dout = '0;
        else if (busy && poll_armed && (addr == last_addr))
            dout = {~last_data[DATA_W-1], last_data[DATA_W-2:0]};
        else
            dout = mem[addr];
    end

    assert_write_and_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> (mem[$past(addr)] == ($past(mem[addr]) & $past(din))));
    assert_erase_fill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |=> ((mem[0] == '1) && (mem[DEPTH-1] == '1)));
    assert_poll_bit_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && busy && poll_armed && (addr == last_addr))
            |-> (dout[DATA_W-1] != mem[addr][DATA_W-1]));
endmodule

// File: rtl/codemem_prog_ctrl.sv
// Module: codemem_prog_ctrl
// Top of the code memory programming controller. Joins the command decoder,
// the address counter, the cycle timer and the array. Assumes synchronous
// inputs. A program edge is accepted only in write or erase mode while ready.
module codemem_prog_ctrl
    import codemem_pkg::*;
#(
    parameter int ADDR_W    = 11,
    parameter int DATA_W    = 8,
    parameter int WR_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              prog_en,
    input  logic              step,
    input  logic [1:0]        mode_sel,
    input  logic              prog_pulse,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              ready
);
    cm_mode_e          mode;
    logic              en_rise, step_rise, prog_rise;
    logic [ADDR_W-1:0] addr;
    logic              busy, wr_go, erase_go;

    cm_cmd_dec u_dec (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .step(step),
        .prog_pulse(prog_pulse), .mode_sel(mode_sel), .mode(mode),
        .en_rise(en_rise), .step_rise(step_rise), .prog_rise(prog_rise)
    );

    cm_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(en_rise), .adv(step_rise), .addr(addr)
    );

    // Accept a program edge only when idle and in a programming command.
    always_comb begin
        wr_go    = prog_rise && ready && (mode == CM_WRITE);
        erase_go = prog_rise && ready && (mode == CM_ERASE);
    end

    cm_wr_timer #(.WR_CYCLES(WR_CYCLES)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(wr_go || erase_go),
        .busy(busy), .ready(ready)
    );

    cm_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .wr_go(wr_go), .erase_go(erase_go),
        .rd_en(mode == CM_READ), .busy(busy), .addr(addr), .din(din),
        .dout(dout)
    );

    assert_quiet_outside_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!prog_en || (mode_sel != 2'b10)) |-> (dout == '0));
    assert_ready_after_reset_R1: assert property (@(posedge clk)
        !rst_n |=> ready);
endmodule

// File: tb/sim_codemem_prog_ctrl.sv
`timescale 1ns/1ps
module sim_codemem_prog_ctrl;
    localparam int AW  = 11;
    localparam int WRC = 6;
    localparam int DEP = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic prog_en = 1'b0;
    logic step = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic prog_pulse = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic ready;

    int checks = 0;
    int errors = 0;
    logic [7:0]    mem_m [DEP];
    logic [AW-1:0] maddr;

    always #2 clk = ~clk;

    codemem_prog_ctrl #(.ADDR_W(AW), .DATA_W(8), .WR_CYCLES(WRC)) u0 (
        .clk(clk), .rst_n(rst_n), .prog_en(prog_en), .step(step),
        .mode_sel(mode_sel), .prog_pulse(prog_pulse), .din(din),
        .dout(dout), .ready(ready)
    );

    function automatic logic [7:0] poll_val(input logic [7:0] v);
        return {~v[7], v[6:0]};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic adv(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); step = 1'b1;
            @(negedge clk); step = 1'b0;
            maddr = maddr + 1'b1;
        end
    endtask

    task automatic rd_chk(input string req);
        @(negedge clk); mode_sel = 2'b10; #1;
        chk(dout == mem_m[maddr], req, dout, mem_m[maddr]);
    endtask

    task automatic en_cycle();
        @(negedge clk); prog_en = 1'b0;
        @(negedge clk); prog_en = 1'b1;
        @(negedge clk);
        maddr = '0;
    endtask

    task automatic do_write(input logic [7:0] d, input bit glitch);
        logic [7:0] stored;
        stored = mem_m[maddr] & d;
        @(negedge clk); mode_sel = 2'b01; din = d; prog_pulse = 1'b1;
        @(negedge clk); prog_pulse = 1'b0; mode_sel = 2'b10;
        mem_m[maddr] = stored;
        for (int j = 0; j < WRC; j++) begin
            #1;
            chk(ready == 1'b0, "R8", ready, 0);
            if (!glitch || j == 0 || j >= 3)
                chk(dout == poll_val(stored), "R10", dout, poll_val(stored));
            if (glitch && j == 1) begin mode_sel = 2'b01; din = 8'h00; prog_pulse = 1'b1; end
            if (glitch && j == 2) begin prog_pulse = 1'b0; mode_sel = 2'b10; end
            @(negedge clk);
        end
        #1;
        chk(ready == 1'b1, "R8", ready, 1);
        chk(dout == stored, glitch ? "R9" : "R10", dout, stored);
    endtask

    task automatic do_erase();
        @(negedge clk); mode_sel = 2'b11; prog_pulse = 1'b1;
        @(negedge clk); prog_pulse = 1'b0;
        for (int j = 0; j < WRC; j++) begin
            #1; chk(ready == 1'b0, "R8", ready, 0);
            @(negedge clk);
        end
        #1; chk(ready == 1'b1, "R8", ready, 1);
        for (int i = 0; i < DEP; i++) mem_m[i] = 8'hFF;
    endtask

    initial begin
        #(4 * 200000);
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h2051));
        for (int i = 0; i < DEP; i++) mem_m[i] = 8'hFF;
        maddr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk(ready == 1'b1, "R1", ready, 1);
        prog_en = 1'b1;
        @(negedge clk);
        rd_chk("R1");
        adv(5); rd_chk("R1");
        // R11: quiet data bus in the other modes and with enable low
        for (int m = 0; m < 4; m++) begin
            if (m != 2) begin
                @(negedge clk); mode_sel = 2'(m); #1;
                chk(dout == 8'h00, "R11", dout, 0);
            end
        end
        @(negedge clk); mode_sel = 2'b10; prog_en = 1'b0; #1;
        chk(dout == 8'h00, "R11", dout, 0);
        en_cycle(); rd_chk("R2");
        // R5 blank write, R6 AND over it, R9 ignored pulse while busy
        do_write(8'hA5, 1'b0); rd_chk("R5");
        do_write(8'h3C, 1'b0); rd_chk("R6");
        adv(1);
        do_write(8'h96, 1'b1); rd_chk("R9");
        // R3 step counting: write a mark and read it back from a fresh count
        adv(3);
        do_write(8'h11, 1'b0);
        en_cycle(); adv(4); rd_chk("R3");
        // R4 wrap
        en_cycle(); adv(DEP - 1);
        do_write(8'h5A, 1'b0); rd_chk("R4");
        adv(1);
        chk(maddr == '0, "R4", maddr, 0);
        rd_chk("R4");
        // Constrained random mix
        en_cycle();
        for (int it = 0; it < 60; it++) begin
            int act;
            act = $urandom_range(0, 9);
            if (act < 4) adv($urandom_range(0, 6));
            else if (act < 8) do_write(8'($urandom), 1'b0);
            else if (act == 8) rd_chk("R6");
            else if (it > 40) begin
                do_erase();
                rd_chk("R7");
            end
        end
        do_erase();
        rd_chk("R7"); adv(17); rd_chk("R7");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule